// File: doc/BRIEF.md
# Multi-mode operand address generator

This block turns one operand specifier into an effective memory address. A request carries a 3-bit mode code, a base register value, an index register value, a signed displacement and a 2-bit element-size code that selects a step of 1, 2, 4 or 8 bytes. Seven of the eight modes are plain arithmetic on those inputs and give a registered result one clock after acceptance. Two of them also return a new base value and a write-back strobe, so that the register file can apply the post-increment or pre-decrement.

The eighth mode is memory-indirect. The base register holds the address of a pointer. The block issues a one-cycle read request for that pointer, stops taking new requests, and presents the returned word as the effective address one clock after the read data is flagged valid.

Top module: `opaddr_gen`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_wb_en` and `mem_req` are 0 and `in_ready` is 1.
- R2: Mode code 0 (register-indirect) yields `out_ea` = base. Mode code 1 (displacement) yields `out_ea` = base + sign-extended displacement.
- R3: Mode code 2 (indexed) yields `out_ea` = base + index.
- R4: Mode code 3 (absolute) yields `out_ea` = sign-extended displacement, and the base is not used.
- R5: Mode code 4 (post-increment) yields `out_ea` = base, `out_wb_en` = 1 and `out_wb_data` = base + d.
- R6: Mode code 5 (pre-decrement) yields `out_ea` = `out_wb_data` = base − d, with `out_wb_en` = 1.
- R7: Mode code 6 (scaled) yields `out_ea` = displacement + base + index × d. The size code maps to d as 0→1, 1→2, 2→4, 3→8.
- R8: `out_wb_en` is 0 for every mode other than 4 and 5.
- R9: For mode codes 0 to 6, a request accepted at a clock edge gives a one-cycle `out_valid` pulse with its result after the next edge. A new request may be accepted on every cycle.
- R10: Mode code 7 (memory-indirect) raises `mem_req` for exactly one cycle with `mem_addr` = base. When `mem_rvalid` is seen, the next cycle shows `out_valid` with `out_ea` = `mem_rdata` and `out_wb_en` = 0.
- R11: While a pointer read is outstanding, `in_ready` is 0 and `in_valid` is ignored, so no result appears before the pointer returns.
- R12: All address arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_mode | input | 3 | Addressing mode code |
| in_base | input | AW | Base register value |
| in_index | input | AW | Index register value |
| in_disp | input | DW | Signed displacement |
| in_size | input | 2 | Element size code (log2 of d) |
| out_valid | output | 1 | Result valid pulse |
| out_ea | output | AW | Effective address |
| out_wb_en | output | 1 | Base register write-back strobe |
| out_wb_data | output | AW | Updated base value |
| mem_req | output | 1 | Pointer read request pulse |
| mem_addr | output | AW | Pointer read address |
| mem_rvalid | input | 1 | Pointer read data valid |
| mem_rdata | input | AW | Pointer read data |

## Verification
The assertions assume that `mem_rvalid` matters only while a pointer read is outstanding, and that memory answers each request once. They also assume that the requester honours `in_ready`, except where a stray request is injected on purpose. The stimulus raises `mem_rvalid` for a single cycle, and only some cycles after each `mem_req`. It drives the ignored direct-mode requests only during that wait, and it issues direct requests back to back only when the block is idle.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    AM_REGIND  = 3'd0,
    AM_DISP    = 3'd1,
    AM_INDEX   = 3'd2,
    AM_ABS     = 3'd3,
    AM_POSTINC = 3'd4,
    AM_PREDEC  = 3'd5,
    AM_SCALED  = 3'd6,
    AM_MEMIND  = 3'd7
  } amode_e;
endpackage

// File: rtl/opaddr_scale.sv
module opaddr_scale #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] val,
  input  logic [1:0]    sz,
  output logic [AW-1:0] shifted
);
  always_comb begin
    unique case (sz)
      2'd0: shifted = val;
      2'd1: shifted = {val[AW-2:0], 1'b0};
      2'd2: shifted = {val[AW-3:0], 2'b0};
      default: shifted = {val[AW-4:0], 3'b0};
    endcase
  end
endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  amode_e        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [DW-1:0] disp,
  input  logic [1:0]    sz,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          is_ind
);
  localparam int EXT = AW - DW;

  logic [AW-1:0] dext, idx_sc, step;

  assign dext = {{EXT{disp[DW-1]}}, disp};

  opaddr_scale #(.AW(AW)) u_idx_scale (.val(index), .sz(sz), .shifted(idx_sc));
  opaddr_scale #(.AW(AW)) u_step_scale (.val(AW'(1)), .sz(sz), .shifted(step));

  always_comb begin
    ea      = base;
    wb_en   = 1'b0;
    wb_data = base;
    is_ind  = 1'b0;
    unique case (mode)
      AM_REGIND:  ea = base;
      AM_DISP:    ea = base + dext;
      AM_INDEX:   ea = base + index;
      AM_ABS:     ea = dext;
      AM_POSTINC: begin
        ea      = base;
        wb_en   = 1'b1;
        wb_data = base + step;
      end
      AM_PREDEC: begin
        ea      = base - step;
        wb_en   = 1'b1;
        wb_data = base - step;
      end
      AM_SCALED:  ea = dext + base + idx_sc;
      AM_MEMIND: begin
        ea     = base;
        is_ind = 1'b1;
      end
      default: ea = base;
    endcase
  end
endmodule

// File: rtl/opaddr_ind_fsm.sv
module opaddr_ind_fsm #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] ptr_addr,
  input  logic          mem_rvalid,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          done
);
  typedef enum logic {S_IDLE, S_WAIT} ist_e;
  ist_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state    <= S_WAIT;
          mem_req  <= 1'b1;
          mem_addr <= ptr_addr;
        end
        S_WAIT: if (mem_rvalid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_WAIT);
  assign done = (state == S_WAIT) && mem_rvalid;

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  p_busy_on_req_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_mode,
  input  logic [AW-1:0] in_base,
  input  logic [AW-1:0] in_index,
  input  logic [DW-1:0] in_disp,
  input  logic [1:0]    in_size,
  output logic          out_valid,
  output logic [AW-1:0] out_ea,
  output logic          out_wb_en,
  output logic [AW-1:0] out_wb_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata
);
  amode_e        mode;
  logic [AW-1:0] c_ea, c_wb_data;
  logic          c_wb_en, c_ind;
  logic          busy, ind_done, accept;
  amode_e        out_mode;

  assign mode     = amode_e'(in_mode);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  opaddr_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode(mode), .base(in_base), .index(in_index), .disp(in_disp), .sz(in_size),
    .ea(c_ea), .wb_en(c_wb_en), .wb_data(c_wb_data), .is_ind(c_ind)
  );

  opaddr_ind_fsm #(.AW(AW)) u_ind (
    .clk(clk), .rst(rst), .start(accept && c_ind), .ptr_addr(c_ea),
    .mem_rvalid(mem_rvalid), .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .done(ind_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_ea      <= '0;
      out_wb_en   <= 1'b0;
      out_wb_data <= '0;
      out_mode    <= AM_REGIND;
    end else begin
      out_valid <= (accept && !c_ind) || ind_done;
      out_wb_en <= accept && !c_ind && c_wb_en;
      if (ind_done) begin
        out_ea   <= mem_rdata;
        out_mode <= AM_MEMIND;
      end else if (accept && !c_ind) begin
        out_ea      <= c_ea;
        out_wb_data <= c_wb_data;
        out_mode    <= mode;
      end
    end
  end

  p_accept_direct_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode != 3'd7) |=> out_valid);
  p_wb_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_wb_en |-> (out_valid && (out_mode == AM_POSTINC || out_mode == AM_PREDEC)));
  p_dec_match_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == AM_PREDEC) |-> (out_wb_data == out_ea));
  p_inc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == AM_POSTINC) |->
      ($countones(out_wb_data - out_ea) == 1 && (out_wb_data - out_ea) <= AW'(8)));
  p_ind_result_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rvalid) |=> (out_valid && out_ea == $past(mem_rdata) && !out_wb_en));
endmodule

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_mode = '0;
  logic [31:0] in_base = '0, in_index = '0;
  logic [15:0] in_disp = '0;
  logic [1:0] in_size = '0;
  logic out_valid, out_wb_en, mem_req;
  logic [31:0] out_ea, out_wb_data, mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [31:0] ea;
    logic        wb;
    logic [31:0] wbd;
    logic [7:0]  tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  opaddr_gen u_opaddr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_base(in_base), .in_index(in_index),
    .in_disp(in_disp), .in_size(in_size), .out_valid(out_valid),
    .out_ea(out_ea), .out_wb_en(out_wb_en), .out_wb_data(out_wb_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [31:0] b,
                                 input logic [31:0] i, input logic [15:0] dp,
                                 input logic [1:0] s);
    exp_t e;
    logic [31:0] dx, d;
    dx = {{16{dp[15]}}, dp};
    case (s)
      2'd0: d = 32'd1;
      2'd1: d = 32'd2;
      2'd2: d = 32'd4;
      default: d = 32'd8;
    endcase
    e.wb = 1'b0; e.wbd = '0; e.tag = {5'd0, m};
    case (m)
      3'd0: e.ea = b;
      3'd1: e.ea = b + dx;
      3'd2: e.ea = b + i;
      3'd3: e.ea = dx;
      3'd4: begin e.ea = b; e.wb = 1'b1; e.wbd = b + d; end
      3'd5: begin e.ea = b - d; e.wb = 1'b1; e.wbd = b - d; end
      default: e.ea = dx + b + i * d;
    endcase
    return e;
  endfunction

  // Monitor: compare each result against the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected result", out_ea, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(out_ea == e.ea, $sformatf("R%0s ea mode %0d",
              (e.tag == 7) ? "10" : (e.tag == 4 ? "5" : (e.tag == 5 ? "6" : "2/3/4/7")),
              e.tag), out_ea, e.ea);
        check(out_wb_en == e.wb, "R8 write-back strobe", {31'd0, out_wb_en}, {31'd0, e.wb});
        if (e.wb) check(out_wb_data == e.wbd, "R5/R6 write-back value", out_wb_data, e.wbd);
      end
    end
  end

  // Driver for direct modes: one request per cycle when called back to back
  task automatic issue(input logic [2:0] m, input logic [31:0] b, input logic [31:0] i,
                       input logic [15:0] dp, input logic [1:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_base = b; in_index = i; in_disp = dp; in_size = s;
    q.push_back(model(m, b, i, dp, s));
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic issue_indirect(input logic [31:0] ptr, input logic [31:0] val,
                                input int gap);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 3'd7; in_base = ptr; in_disp = 16'h0044;
    e.ea = val; e.wb = 1'b0; e.wbd = '0; e.tag = 8'd7;
    q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(mem_req == 1'b1, "R10 request raised", {31'd0, mem_req}, 32'd1);
    check(mem_addr == ptr, "R10 pointer address", mem_addr, ptr);
    check(in_ready == 1'b0, "R11 ready low while waiting", {31'd0, in_ready}, 32'd0);
    // stray direct request during the wait must be ignored
    in_valid = 1'b1; in_mode = 3'd1; in_base = 32'hDEAD0000;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      check(mem_req == 1'b0, "R10 request is one pulse", {31'd0, mem_req}, 32'd0);
      check(out_valid == 1'b0, "R11 no result before pointer", {31'd0, out_valid}, 32'd0);
    end
    in_valid = 1'b0;
    mem_rvalid = 1'b1; mem_rdata = val;
    @(posedge clk);
    #1 mem_rvalid = 1'b0; mem_rdata = 32'h0BAD_0BAD;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready restored", {31'd0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid reset", {31'd0, out_valid}, 32'd0);
    check(out_wb_en == 1'b0, "R1 wb_en reset", {31'd0, out_wb_en}, 32'd0);
    check(mem_req == 1'b0, "R1 mem_req reset", {31'd0, mem_req}, 32'd0);
    check(in_ready == 1'b1, "R1 ready reset", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;

    // R2, R3, R4 back to back (R9 throughput)
    issue(3'd0, 32'h0000_1000, 32'h5, 16'h0100, 2'd0);
    issue(3'd1, 32'h0000_2000, 32'h0, 16'hFFF0, 2'd0);
    issue(3'd1, 32'h0000_2000, 32'h0, 16'h0123, 2'd0);
    issue(3'd2, 32'h0001_0000, 32'h0000_0abc, 16'h7777, 2'd1);
    issue(3'd3, 32'h1234_5678, 32'h0, 16'h7FFF, 2'd0);
    issue(3'd3, 32'h1234_5678, 32'h0, 16'hFFFF, 2'd0);
    // R5, R6 across sizes
    for (int s = 0; s < 4; s++) issue(3'd4, 32'h0000_4000 + s, 32'h0, 16'h0, 2'(s));
    for (int s = 0; s < 4; s++) issue(3'd5, 32'h0000_8000, 32'h0, 16'h0, 2'(s));
    // R7 scaled, every size
    for (int s = 0; s < 4; s++) issue(3'd6, 32'h0010_0000, 32'h0000_0013, 16'hFFFC, 2'(s));
    // R12 wrap cases
    issue(3'd1, 32'hFFFF_FFF0, 32'h0, 16'h0020, 2'd0);
    issue(3'd5, 32'h0000_0000, 32'h0, 16'h0, 2'd0);
    issue(3'd4, 32'hFFFF_FFFC, 32'h0, 16'h0, 2'd3);
    issue(3'd6, 32'hFFFF_FF00, 32'h8000_0001, 16'h0100, 2'd1);
    repeat (2) @(negedge clk);
    // R10, R11 indirect with different wait lengths
    issue_indirect(32'h0000_0C00, 32'hCAFE_F00D, 1);
    issue_indirect(32'hFFFF_FFF8, 32'h0000_0040, 4);
    // direct after indirect
    issue(3'd2, 32'h0000_0010, 32'h0000_0020, 16'h0, 2'd0);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9 all results seen", q.size(), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule